// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block decides, once per clock, the address of the next instruction a small 8-bit controller fetches. A decoder in front of it presents one flow operation per cycle together with a condition selector, a 10-bit target address and the live carry and zero flags. The sequencer updates its program counter, which is also the instruction memory address. It owns a return-address stack of 31 entries, the interrupt-enable flag, and a saved copy of carry and zero that is taken when an interrupt is accepted.

A subroutine return resumes one past the saved address, because the saved address is the call itself. A return from an interrupt resumes at the saved address exactly, because that instruction was preempted and never ran. In the same step it hands the saved carry and zero back to the flag logic through a one-cycle restore pulse, and it sets or clears interrupt enable. An accepted interrupt overrides whatever operation is presented in that cycle. It pushes the program counter, saves the flags, clears enable, moves to a fixed vector and pulses an acknowledge.

Top module: `prog_seq`

## Requirements
- R1: While `rst` is high at a clock edge the sequencer loads `pc` = 0, clears `int_en`, `irq_ack` and `flag_restore`, and empties the stack.
- R2: When `flow_op` is 0 (no flow change), or when a conditional operation's condition fails, `pc` becomes `pc`+1 modulo 1024 at the next edge.
- R3: `flow_op` = 1 is a jump that loads `target` into `pc`. `cond_sel` values 0 to 3 mean always, 4 carry set, 5 carry clear, 6 zero set and 7 zero clear. The condition is evaluated on `carry_in` and `zero_in` in the same cycle.
- R4: `flow_op` = 2 is a call with the same conditions as R3. When taken it pushes the current `pc` and loads `target`. When not taken the stack is unchanged.
- R5: `flow_op` = 3 is a return with the same conditions. When taken it loads the most recently pushed address plus one and pops it.
- R6: `flow_op` = 4 or 5 returns from an interrupt. It loads the popped address without adding one and pulses `flag_restore` for one cycle with the saved carry and zero on `carry_restore` and `zero_restore`. It sets `int_en` to 1 for code 4 and to 0 for code 5.
- R7: `flow_op` = 6 sets and `flow_op` = 7 clears `int_en`. Both advance `pc` by one.
- R8: When `int_en` and `irq_req` are both high, the presented operation is discarded. `pc` is pushed, carry and zero are saved, `int_en` clears, `pc` loads the vector 0x3FF, and `irq_ack` is high for exactly that one cycle.
- R9: While `int_en` is low, `irq_req` has no effect: `pc` follows the presented operation and `irq_ack` stays low.
- R10: The stack holds 31 addresses. A 32nd push wraps and overwrites the oldest position still in use, so the first return after 32 calls gives the 32nd call's address. The 32nd return in a row gives the same address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flow_op | input | 3 | Flow operation code (see R2 to R7) |
| cond_sel | input | 3 | Condition selector (see R3) |
| target | input | 10 | Jump or call destination |
| carry_in | input | 1 | Live carry flag |
| zero_in | input | 1 | Live zero flag |
| irq_req | input | 1 | Interrupt request |
| pc | output | 10 | Program counter and instruction memory address |
| int_en | output | 1 | Interrupt-enable flag |
| irq_ack | output | 1 | Interrupt accepted, one-cycle pulse |
| flag_restore | output | 1 | Restore pulse for carry and zero |
| carry_restore | output | 1 | Saved carry to restore |
| zero_restore | output | 1 | Saved zero to restore |

## Verification
The assertions assume that `rst` is asserted before the first edge. They also assume the decoder never presents a return or interrupt return with an empty stack, because the popped value is then undefined and the restore pulse carries whatever flags were last saved. The stimulus starts with a reset and pairs every return with an earlier call or accepted interrupt. It keeps `irq_req` low whenever an accepted interrupt would disturb the call depth under test. Because `irq_req` is only acted on while enabled, the bench holds it high for one cycle after acceptance to show that the request is ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_JUMP     = 3'd1,
    OP_CALL     = 3'd2,
    OP_RET      = 3'd3,
    OP_RETI_EN  = 3'd4,
    OP_RETI_DIS = 3'd5,
    OP_IEN      = 3'd6,
    OP_IDIS     = 3'd7
  } flow_op_e;

  // cond_sel[2]==0 : unconditional; [1] picks zero over carry; [0] inverts
  function automatic logic cond_met(input logic [2:0] sel, input logic c, input logic z);
    logic flag;
    flag = sel[1] ? z : c;
    if (!sel[2]) return 1'b1;
    return sel[0] ? ~flag : flag;
  endfunction

  function automatic int unsigned ring_up(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ring_down(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval (
  input  logic [2:0] sel,
  input  logic       carry,
  input  logic       zero,
  output logic       pass
);
  import seq_pkg::*;

  always_comb pass = cond_met(sel, carry, zero);

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int DEPTH = 31,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr,
  output logic [$clog2(DEPTH)-1:0] ptr
);
  import seq_pkg::*;

  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_up, ptr_dn;

  always_comb begin
    ptr_up = PW'(ring_up(32'(ptr), DEPTH));
    ptr_dn = PW'(ring_down(32'(ptr), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (push) ptr <= ptr_up;
    else if (pop)  ptr <= ptr_dn;
  end

  always_ff @(posedge clk) begin
    if (!rst && push) mem[ptr_up] <= push_addr;
  end

  assign top_addr = mem[ptr];

endmodule

// File: rtl/seq_irq_ctl.sv
module seq_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic carry_in,
  input  logic zero_in,
  input  logic set_en,
  input  logic clr_en,
  input  logic restore,
  output logic take,
  output logic ien,
  output logic ack,
  output logic flag_restore,
  output logic carry_out,
  output logic zero_out
);
  logic saved_c, saved_z;

  assign take = ien & irq_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien          <= 1'b0;
      ack          <= 1'b0;
      flag_restore <= 1'b0;
      saved_c      <= 1'b0;
      saved_z      <= 1'b0;
      carry_out    <= 1'b0;
      zero_out     <= 1'b0;
    end else begin
      ack          <= take;
      flag_restore <= restore;
      if (take) begin
        saved_c <= carry_in;
        saved_z <= zero_in;
      end
      if (restore) begin
        carry_out <= saved_c;
        zero_out  <= saved_z;
      end
      if (take)        ien <= 1'b0;
      else if (set_en) ien <= 1'b1;
      else if (clr_en) ien <= 1'b0;
    end
  end

endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int          AW     = 10,
  parameter int          DEPTH  = 31,
  parameter logic [9:0]  VECTOR = 10'h3FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    flow_op,
  input  logic [2:0]    cond_sel,
  input  logic [AW-1:0] target,
  input  logic          carry_in,
  input  logic          zero_in,
  input  logic          irq_req,
  output logic [AW-1:0] pc,
  output logic          int_en,
  output logic          irq_ack,
  output logic          flag_restore,
  output logic          carry_restore,
  output logic          zero_restore
);
  import seq_pkg::*;

  localparam int PW = $clog2(DEPTH);

  function automatic logic [AW-1:0] step_one(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  flow_op_e      op;
  logic          cond_pass, take_irq;
  logic          do_jump, do_call, do_ret, do_reti;
  logic          ien_set, ien_clr;
  logic          stk_push, stk_pop;
  logic [AW-1:0] stk_top, pc_next;
  logic [PW-1:0] stk_ptr;

  assign op = flow_op_e'(flow_op);

  seq_cond_eval u_cond (
    .sel   (cond_sel),
    .carry (carry_in),
    .zero  (zero_in),
    .pass  (cond_pass)
  );

  always_comb begin
    do_jump = !take_irq && op == OP_JUMP && cond_pass;
    do_call = !take_irq && op == OP_CALL && cond_pass;
    do_ret  = !take_irq && op == OP_RET  && cond_pass;
    do_reti = !take_irq && (op == OP_RETI_EN || op == OP_RETI_DIS);
    ien_set = !take_irq && (op == OP_RETI_EN  || op == OP_IEN);
    ien_clr = !take_irq && (op == OP_RETI_DIS || op == OP_IDIS);
    stk_push = take_irq | do_call;
    stk_pop  = do_ret | do_reti;
  end

  seq_ret_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_addr (pc),
    .top_addr  (stk_top),
    .ptr       (stk_ptr)
  );

  seq_irq_ctl u_irq (
    .clk          (clk),
    .rst          (rst),
    .irq_req      (irq_req),
    .carry_in     (carry_in),
    .zero_in      (zero_in),
    .set_en       (ien_set),
    .clr_en       (ien_clr),
    .restore      (do_reti),
    .take         (take_irq),
    .ien          (int_en),
    .ack          (irq_ack),
    .flag_restore (flag_restore),
    .carry_out    (carry_restore),
    .zero_out     (zero_restore)
  );

  always_comb begin
    if (take_irq)                pc_next = AW'(VECTOR);
    else if (do_jump || do_call) pc_next = target;
    else if (do_ret)             pc_next = step_one(stk_top);
    else if (do_reti)            pc_next = stk_top;
    else                         pc_next = step_one(pc);
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int         AW     = 10,
  parameter int         PW     = 5,
  parameter logic [9:0] VECTOR = 10'h3FF
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    flow_op,
  input logic [2:0]    cond_sel,
  input logic [AW-1:0] target,
  input logic [AW-1:0] pc,
  input logic          int_en,
  input logic          irq_ack,
  input logic          flag_restore,
  input logic          take_irq,
  input logic          do_reti,
  input logic [PW-1:0] stk_ptr
);

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && !int_en && !irq_ack && !flag_restore && stk_ptr == '0));

  // R2: sequential advance
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!take_irq && flow_op == 3'd0) |=> pc == $past(pc) + AW'(1));

  // R3: unconditional jump
  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (!take_irq && flow_op == 3'd1 && !cond_sel[2]) |=> pc == $past(target));

  // R4: unconditional call
  p_call_r4: assert property (@(posedge clk) disable iff (rst)
    (!take_irq && flow_op == 3'd2 && !cond_sel[2]) |=> pc == $past(target));

  // R6: return from interrupt pulses restore once
  p_restore_r6: assert property (@(posedge clk) disable iff (rst)
    do_reti |=> flag_restore);
  p_restore_excl_r6: assert property (@(posedge clk) disable iff (rst)
    flag_restore |-> !irq_ack);

  // R7: enable operation
  p_ien_r7: assert property (@(posedge clk) disable iff (rst)
    (!take_irq && flow_op == 3'd6) |=> int_en);
  p_idis_r7: assert property (@(posedge clk) disable iff (rst)
    (!take_irq && flow_op == 3'd7) |=> !int_en);

  // R8: acceptance
  p_ack_vector_r8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (pc == AW'(VECTOR) && !int_en));
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  // R9: no acceptance while disabled
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq_ack);

endmodule

bind prog_seq seq_checker #(.AW(AW), .PW(PW), .VECTOR(VECTOR)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flow_op      (flow_op),
  .cond_sel     (cond_sel),
  .target       (target),
  .pc           (pc),
  .int_en       (int_en),
  .irq_ack      (irq_ack),
  .flag_restore (flag_restore),
  .take_irq     (take_irq),
  .do_reti      (do_reti),
  .stk_ptr      (stk_ptr)
);

// File: tb/prog_seq_bench.sv
module prog_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] flow_op = 3'd0, cond_sel = 3'd0;
  logic [9:0] target = '0;
  logic       carry_in = 1'b0, zero_in = 1'b0, irq_req = 1'b0;
  logic [9:0] pc;
  logic       int_en, irq_ack, flag_restore, carry_restore, zero_restore;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prog_seq u_prog_seq (
    .clk(clk), .rst(rst), .flow_op(flow_op), .cond_sel(cond_sel),
    .target(target), .carry_in(carry_in), .zero_in(zero_in), .irq_req(irq_req),
    .pc(pc), .int_en(int_en), .irq_ack(irq_ack), .flag_restore(flag_restore),
    .carry_restore(carry_restore), .zero_restore(zero_restore)
  );

  typedef struct packed {
    logic [9:0] pc;
    logic ack, ien, fr, rc, rz;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // independent reference state
  logic [9:0] m_pc = '0;
  logic [9:0] m_stk [31];
  int         m_sp = 0;
  bit         m_ien = 0, m_sc = 0, m_sz = 0, m_rc = 0, m_rz = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [2:0] cs, input bit c, input bit z);
    case (cs)
      3'd4: return c;
      3'd5: return !c;
      3'd6: return z;
      3'd7: return !z;
      default: return 1'b1;
    endcase
  endfunction

  task automatic m_push(input logic [9:0] a);
    m_sp = (m_sp + 1) % 31;
    m_stk[m_sp] = a;
  endtask

  task automatic m_pop(output logic [9:0] a);
    a = m_stk[m_sp];
    m_sp = (m_sp + 30) % 31;
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(input logic [2:0] op, input logic [2:0] cs, input logic [9:0] tgt,
                      input bit c, input bit z, input bit irq, input string tag);
    exp_t e;
    logic [9:0] a;
    flow_op = op; cond_sel = cs; target = tgt;
    carry_in = c; zero_in = z; irq_req = irq;
    e = '0;
    if (m_ien && irq) begin
      m_push(m_pc); m_sc = c; m_sz = z; m_ien = 0;
      m_pc = 10'h3FF; e.ack = 1;
    end else begin
      case (op)
        3'd1: m_pc = cond_ok(cs, c, z) ? tgt : m_pc + 10'd1;
        3'd2: if (cond_ok(cs, c, z)) begin m_push(m_pc); m_pc = tgt; end
              else m_pc = m_pc + 10'd1;
        3'd3: if (cond_ok(cs, c, z)) begin m_pop(a); m_pc = a + 10'd1; end
              else m_pc = m_pc + 10'd1;
        3'd4, 3'd5: begin
          m_pop(a); m_pc = a; m_ien = (op == 3'd4);
          m_rc = m_sc; m_rz = m_sz; e.fr = 1;
        end
        3'd6: begin m_ien = 1; m_pc = m_pc + 10'd1; end
        3'd7: begin m_ien = 0; m_pc = m_pc + 10'd1; end
        default: m_pc = m_pc + 10'd1;
      endcase
    end
    e.pc = m_pc; e.ien = m_ien; e.rc = m_rc; e.rz = m_rz;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares two time units after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "pc", pc, e.pc);
        chk(t, "irq_ack", irq_ack, e.ack);
        chk(t, "int_en", int_en, e.ien);
        chk(t, "flag_restore", flag_restore, e.fr);
        if (e.fr) begin
          chk(t, "carry_restore", carry_restore, e.rc);
          chk(t, "zero_restore", zero_restore, e.rz);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "pc", pc, 0);
    chk("R1", "int_en", int_en, 0);
    chk("R1", "irq_ack", irq_ack, 0);
    chk("R1", "flag_restore", flag_restore, 0);

    // R2: sequential advance, with wrap at the top of the address space
    step(3'd0, 3'd0, 10'h000, 0, 0, 0, "R2");
    step(3'd0, 3'd0, 10'h000, 1, 1, 1, "R2");
    step(3'd1, 3'd0, 10'h3FE, 0, 0, 0, "R3");
    step(3'd0, 3'd0, 10'h000, 0, 0, 0, "R2");
    step(3'd0, 3'd0, 10'h000, 0, 0, 0, "R2_wrap");

    // R3: each condition, taken and not taken
    for (int cs = 4; cs < 8; cs++) begin
      for (int f = 0; f < 2; f++) begin
        step(3'd1, 3'(cs), 10'(16 * cs + f), f[0], f[0], 0, "R3");
      end
    end

    // R4 / R5: calls and returns, conditional forms
    step(3'd2, 3'd0, 10'h100, 0, 0, 0, "R4");
    step(3'd0, 3'd0, 10'h000, 0, 0, 0, "R4");
    step(3'd2, 3'd6, 10'h200, 0, 0, 0, "R4_not_taken");
    step(3'd2, 3'd5, 10'h180, 0, 0, 0, "R4_cond");
    step(3'd3, 3'd4, 10'h000, 0, 0, 0, "R5_not_taken");
    step(3'd3, 3'd7, 10'h000, 0, 0, 0, "R5");
    step(3'd3, 3'd0, 10'h000, 0, 0, 0, "R5");

    // R7: enable and disable
    step(3'd6, 3'd0, 10'h000, 0, 0, 0, "R7");
    step(3'd7, 3'd0, 10'h000, 0, 0, 0, "R7");
    step(3'd0, 3'd0, 10'h000, 0, 0, 1, "R9");
    step(3'd6, 3'd0, 10'h000, 0, 0, 0, "R7");

    // R8 / R9 / R6: accept, ignore while disabled, return disabling
    step(3'd0, 3'd0, 10'h000, 1, 0, 1, "R8");
    step(3'd1, 3'd0, 10'h050, 0, 1, 1, "R9");
    step(3'd5, 3'd0, 10'h000, 0, 1, 0, "R6_dis");
    step(3'd6, 3'd0, 10'h000, 0, 0, 0, "R7");
    // accepted request overrides a presented jump
    step(3'd1, 3'd0, 10'h077, 0, 1, 1, "R8_override");
    step(3'd0, 3'd0, 10'h000, 0, 0, 0, "R8");
    step(3'd4, 3'd0, 10'h000, 1, 0, 0, "R6_en");
    step(3'd0, 3'd0, 10'h000, 0, 0, 0, "R6");
    step(3'd7, 3'd0, 10'h000, 0, 0, 0, "R7");

    // R10: 31 calls then 31 returns
    for (int i = 0; i < 31; i++) step(3'd2, 3'd0, 10'(8 * i + 3), 0, 0, 0, "R10_fill");
    for (int i = 0; i < 31; i++) step(3'd3, 3'd0, 10'h000, 0, 0, 0, "R10_drain");
    // 32 calls then 32 returns: overwrite shows up first and last
    for (int i = 0; i < 32; i++) step(3'd2, 3'd0, 10'(5 * i + 1), 0, 0, 0, "R10_wrap");
    for (int i = 0; i < 32; i++) step(3'd3, 3'd0, 10'h000, 0, 0, 0, "R10_wrap");

    step(3'd0, 3'd0, 10'h000, 0, 0, 0, "R2");
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule